// File: doc/BRIEF.md
# Decimal Adjust Arithmetic Unit

This unit applies the six decimal corrections that follow, or prepare for, binary arithmetic on BCD data held in an 8-bit low byte (AL) and an 8-bit high byte (AH). The packed corrections repair a byte after a binary addition or subtraction of two-digit BCD values. The unpacked corrections repair a single digit after addition or subtraction, and carry into or borrow from AH. One more operation splits a binary product into two decimal digits. The last merges two decimal digits into one binary value before a division.

The caller presents an operation code, AL, AH and the incoming carry (CF) and auxiliary carry (AF) flags with `in_valid`. The corrected bytes and flags appear on registered outputs one clock later, with `out_valid` set. The adder, multiplier and divider around the unit are not part of it. The same is true of the parity, sign and zero flag logic.

Top module: `dec_adjust_unit`

## Requirements
- R1: A transfer with `in_valid` high gives `out_valid` high on the next clock edge, carrying that transfer's result. A cycle with `in_valid` low gives `out_valid` low, and `out_al`, `out_ah`, `out_cf` and `out_af` keep their previous values.
- R2: While `rst_n` is low, every output is 0.
- R3: Op code 0 (packed add correction). 0x06 is added when AL[3:0] > 9 or AF = 1, and AF out shows whether this was done. 0x60 is added when the original AL > 0x99 or CF = 1, and CF out shows whether this was done. Both additions are modulo 256. AH passes through unchanged.
- R4: Op code 1 (packed subtract correction) follows the rule of R3 but subtracts 0x06 and 0x60, modulo 256. AH passes through unchanged.
- R5: Op code 2 (unpacked add correction). The unit triggers when AL[3:0] > 9 or AF = 1. On a trigger, AL becomes ((AL + 6) mod 16), AH becomes AH + 1 modulo 256, and CF and AF are both set. Otherwise AL becomes AL[3:0], AH is unchanged, and CF and AF are both cleared. AL[7:4] out is always 0.
- R6: Op code 3 (unpacked subtract correction) uses the trigger of R5. On a trigger, AL becomes ((AL - 6) mod 16), AH becomes AH - 1 modulo 256, and CF and AF are both set. Otherwise AL becomes AL[3:0], AH is unchanged, and both flags are cleared.
- R7: Op code 4 (product split) gives AH = AL / 10 and AL = AL mod 10 over all 256 AL values, and clears CF and AF.
- R8: Op code 5 (dividend merge) gives AL = (AH * 10 + AL) mod 256 and AH = 0, and clears CF and AF.
- R9: Op codes 6 and 7 pass AL, AH, CF and AF through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and op code are presented this cycle |
| in_op | input | 3 | Operation select (codes as in R3 to R9) |
| in_al | input | 8 | Low accumulator byte |
| in_ah | input | 8 | High accumulator byte |
| in_cf | input | 1 | Incoming carry flag |
| in_af | input | 1 | Incoming auxiliary carry flag |
| out_valid | output | 1 | Result registered from the previous cycle's transfer |
| out_al | output | 8 | Corrected low byte |
| out_ah | output | 8 | Corrected high byte |
| out_cf | output | 1 | Resulting carry flag |
| out_af | output | 1 | Resulting auxiliary carry flag |

## Verification
Some properties hold on every cycle, and the assertions check those. They cover the one-cycle valid timing and holding the outputs while idle. They also cover the cleared upper nibble and the equal flags after an unpacked correction, the digit ranges after a product split, and the cleared AH and flags after a merge. The exact corrected values can only be shown by the bench's scenarios. These include the 0x06/0x60 choice at the 9/0x99 boundaries, the AH wrap at 0xFF and 0x00, the split quotient and remainder for every byte, and the merge truncation. The bench sweeps every op code against every AL value and all four incoming flag combinations, with AH varied alongside.

// File: rtl/dau_pkg.sv
package dau_pkg;

    localparam int BYTE_W  = 8;
    localparam int NIB_W   = BYTE_W / 2;
    localparam int OP_W    = 3;
    localparam int PROD_W  = 2 * BYTE_W;
    localparam int RECIP_SHIFT = 11;
    localparam int QUOT_W  = PROD_W - RECIP_SHIFT;

    localparam logic [OP_W-1:0] OP_PK_ADD   = 3'd0;
    localparam logic [OP_W-1:0] OP_PK_SUB   = 3'd1;
    localparam logic [OP_W-1:0] OP_UP_ADD   = 3'd2;
    localparam logic [OP_W-1:0] OP_UP_SUB   = 3'd3;
    localparam logic [OP_W-1:0] OP_SPLIT    = 3'd4;
    localparam logic [OP_W-1:0] OP_MERGE    = 3'd5;

    localparam logic [NIB_W-1:0]  NIB_MAX_DIGIT  = 4'd9;
    localparam logic [BYTE_W-1:0] BYTE_MAX_BCD   = 8'h99;
    localparam logic [NIB_W-1:0]  NIB_FIX        = 4'h6;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] al;
        logic [BYTE_W-1:0] ah;
        logic              cf;
        logic              af;
    } dau_result_t;

endpackage

// File: rtl/dau_packed_adj.sv
module dau_packed_adj
    import dau_pkg::*;
#(
    parameter bit SUBTRACT = 1'b0
) (
    input  logic [BYTE_W-1:0] al_i,
    input  logic              cf_i,
    input  logic              af_i,
    output logic [BYTE_W-1:0] al_o,
    output logic              cf_o,
    output logic              af_o
);

    logic              low_fix;
    logic              high_fix;
    logic [BYTE_W-1:0] step;

    always_comb begin
        low_fix  = (al_i[NIB_W-1:0] > NIB_MAX_DIGIT) || af_i;
        high_fix = (al_i > BYTE_MAX_BCD) || cf_i;
        step     = {(high_fix ? NIB_FIX : '0), (low_fix ? NIB_FIX : '0)};
        cf_o     = high_fix;
        af_o     = low_fix;
    end

    generate
        if (SUBTRACT) begin : g_sub
            assign al_o = al_i - step;
        end else begin : g_add
            assign al_o = al_i + step;
        end
    endgenerate

endmodule

// File: rtl/dau_unpacked_adj.sv
module dau_unpacked_adj
    import dau_pkg::*;
#(
    parameter bit SUBTRACT = 1'b0
) (
    input  logic [BYTE_W-1:0] al_i,
    input  logic [BYTE_W-1:0] ah_i,
    input  logic              af_i,
    output logic [BYTE_W-1:0] al_o,
    output logic [BYTE_W-1:0] ah_o,
    output logic              flag_o
);

    logic             trigger;
    logic [NIB_W-1:0] digit;
    logic [NIB_W-1:0] fix_amt;

    always_comb begin
        trigger = (al_i[NIB_W-1:0] > NIB_MAX_DIGIT) || af_i;
        fix_amt = trigger ? NIB_FIX : '0;
        flag_o  = trigger;
    end

    generate
        if (SUBTRACT) begin : g_sub
            assign digit = al_i[NIB_W-1:0] - fix_amt;
            assign ah_o  = ah_i - {{(BYTE_W-1){1'b0}}, trigger};
        end else begin : g_add
            assign digit = al_i[NIB_W-1:0] + fix_amt;
            assign ah_o  = ah_i + {{(BYTE_W-1){1'b0}}, trigger};
        end
    endgenerate

    assign al_o = {{(BYTE_W-NIB_W){1'b0}}, digit};

endmodule

// File: rtl/dau_split_merge.sv
module dau_split_merge
    import dau_pkg::*;
(
    input  logic [BYTE_W-1:0] al_i,
    input  logic [BYTE_W-1:0] ah_i,
    output logic [BYTE_W-1:0] split_hi_o,
    output logic [BYTE_W-1:0] split_lo_o,
    output logic [BYTE_W-1:0] merge_o
);

    // Reciprocal multiply: x * 205 / 2048 equals floor(x / 10) for x < 256.
    logic [PROD_W-1:0] wide;
    logic [PROD_W-1:0] recip_prod;
    logic [QUOT_W-1:0] quot;
    logic [BYTE_W-1:0] quot_b;
    logic [BYTE_W-1:0] quot_x10;
    logic [BYTE_W-1:0] ah_x10;

    always_comb begin
        wide       = {{(PROD_W-BYTE_W){1'b0}}, al_i};
        recip_prod = (wide << 7) + (wide << 6) + (wide << 3) + (wide << 2) + wide;
        quot       = QUOT_W'(recip_prod >> RECIP_SHIFT);
        quot_b     = {{(BYTE_W-QUOT_W){1'b0}}, quot};
        quot_x10   = (quot_b << 3) + (quot_b << 1);
        split_hi_o = quot_b;
        split_lo_o = al_i - quot_x10;
        ah_x10     = (ah_i << 3) + (ah_i << 1);
        merge_o    = ah_x10 + al_i;
    end

endmodule

// File: rtl/dec_adjust_unit.sv
module dec_adjust_unit
    import dau_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [2:0] in_op,
    input  logic [7:0] in_al,
    input  logic [7:0] in_ah,
    input  logic       in_cf,
    input  logic       in_af,
    output logic       out_valid,
    output logic [7:0] out_al,
    output logic [7:0] out_ah,
    output logic       out_cf,
    output logic       out_af
);

    logic [BYTE_W-1:0] pa_al, ps_al;
    logic              pa_cf, pa_af, ps_cf, ps_af;
    logic [BYTE_W-1:0] ua_al, ua_ah, us_al, us_ah;
    logic              ua_flag, us_flag;
    logic [BYTE_W-1:0] sp_hi, sp_lo, mg_al;

    dau_packed_adj #(.SUBTRACT(1'b0)) u_pk_add (
        .al_i(in_al), .cf_i(in_cf), .af_i(in_af),
        .al_o(pa_al), .cf_o(pa_cf), .af_o(pa_af)
    );

    dau_packed_adj #(.SUBTRACT(1'b1)) u_pk_sub (
        .al_i(in_al), .cf_i(in_cf), .af_i(in_af),
        .al_o(ps_al), .cf_o(ps_cf), .af_o(ps_af)
    );

    dau_unpacked_adj #(.SUBTRACT(1'b0)) u_up_add (
        .al_i(in_al), .ah_i(in_ah), .af_i(in_af),
        .al_o(ua_al), .ah_o(ua_ah), .flag_o(ua_flag)
    );

    dau_unpacked_adj #(.SUBTRACT(1'b1)) u_up_sub (
        .al_i(in_al), .ah_i(in_ah), .af_i(in_af),
        .al_o(us_al), .ah_o(us_ah), .flag_o(us_flag)
    );

    dau_split_merge u_split_merge (
        .al_i(in_al), .ah_i(in_ah),
        .split_hi_o(sp_hi), .split_lo_o(sp_lo), .merge_o(mg_al)
    );

    dau_result_t res_d, res_q;

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            case (in_op)
                OP_PK_ADD: res_d = '{valid: 1'b1, al: pa_al, ah: in_ah, cf: pa_cf, af: pa_af};
                OP_PK_SUB: res_d = '{valid: 1'b1, al: ps_al, ah: in_ah, cf: ps_cf, af: ps_af};
                OP_UP_ADD: res_d = '{valid: 1'b1, al: ua_al, ah: ua_ah, cf: ua_flag, af: ua_flag};
                OP_UP_SUB: res_d = '{valid: 1'b1, al: us_al, ah: us_ah, cf: us_flag, af: us_flag};
                OP_SPLIT:  res_d = '{valid: 1'b1, al: sp_lo, ah: sp_hi, cf: 1'b0, af: 1'b0};
                OP_MERGE:  res_d = '{valid: 1'b1, al: mg_al, ah: '0, cf: 1'b0, af: 1'b0};
                default:   res_d = '{valid: 1'b1, al: in_al, ah: in_ah, cf: in_cf, af: in_af};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign out_al    = res_q.al;
    assign out_ah    = res_q.ah;
    assign out_cf    = res_q.cf;
    assign out_af    = res_q.af;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_al) && $stable(out_ah)
                       && $stable(out_cf) && $stable(out_af))); // R1
    AST_UNPACKED_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == OP_UP_ADD || in_op == OP_UP_SUB))
        |=> (out_al[7:4] == 4'h0 && out_cf == out_af)); // R5 R6
    AST_SPLIT_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_SPLIT)
        |=> (out_al < 8'd10 && out_ah < 8'd26 && !out_cf && !out_af)); // R7
    AST_MERGE_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_MERGE)
        |=> (out_ah == 8'h00 && !out_cf && !out_af)); // R8
    AST_PACKED_KEEPS_AH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == OP_PK_ADD || in_op == OP_PK_SUB))
        |=> (out_ah == $past(in_ah))); // R3 R4

endmodule

// File: tb/dec_adjust_unit_test.sv
module dec_adjust_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_op = '0;
    logic [7:0] in_al = '0, in_ah = '0;
    logic       in_cf = 1'b0, in_af = 1'b0;
    logic       out_valid;
    logic [7:0] out_al, out_ah;
    logic       out_cf, out_af;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dec_adjust_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_al(in_al), .in_ah(in_ah), .in_cf(in_cf), .in_af(in_af),
        .out_valid(out_valid), .out_al(out_al), .out_ah(out_ah),
        .out_cf(out_cf), .out_af(out_af)
    );

    function automatic string req_of(int op);
        case (op)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Arithmetic reference: returns {valid, al, ah, cf, af}.
    function automatic logic [18:0] ref_model(int op, int al, int ah, int cf, int af);
        int r_al, r_ah, r_cf, r_af;
        r_al = al; r_ah = ah; r_cf = cf; r_af = af;
        case (op)
            0, 1: begin
                r_af = ((al % 16) > 9 || af != 0) ? 1 : 0;
                r_cf = (al > 153 || cf != 0) ? 1 : 0;
                if (op == 0) r_al = al + 6 * r_af + 96 * r_cf;
                else         r_al = al - 6 * r_af - 96 * r_cf;
                r_al = ((r_al % 256) + 256) % 256;
            end
            2, 3: begin
                r_cf = ((al % 16) > 9 || af != 0) ? 1 : 0;
                r_af = r_cf;
                if (op == 2) begin
                    r_al = ((al % 16) + 6 * r_cf) % 16;
                    r_ah = (ah + r_cf) % 256;
                end else begin
                    r_al = ((al % 16) - 6 * r_cf + 16) % 16;
                    r_ah = (ah - r_cf + 256) % 256;
                end
            end
            4: begin
                r_ah = al / 10; r_al = al % 10; r_cf = 0; r_af = 0;
            end
            5: begin
                r_al = (ah * 10 + al) % 256; r_ah = 0; r_cf = 0; r_af = 0;
            end
            default: ;
        endcase
        return {1'b1, 8'(r_al), 8'(r_ah), 1'(r_cf), 1'(r_af)};
    endfunction

    task automatic check(string req, logic [18:0] got, logic [18:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got v=%0b al=%02h ah=%02h cf=%0b af=%0b expected v=%0b al=%02h ah=%02h cf=%0b af=%0b",
                     req, got[18], got[17:10], got[9:2], got[1], got[0],
                     exp[18], exp[17:10], exp[9:2], exp[1], exp[0]);
        end
    endtask

    function automatic logic [18:0] outs();
        return {out_valid, out_al, out_ah, out_cf, out_af};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stimulus
        logic [18:0] exp;
        logic [18:0] held;
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2", outs(), 19'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", outs(), 19'h0);

        for (int op = 0; op < 8; op++) begin
            for (int al = 0; al < 256; al++) begin
                for (int fl = 0; fl < 4; fl++) begin
                    int ah;
                    ah = (al ^ 8'h5A) + fl * 37 + op;
                    ah = ah % 256;
                    in_valid = 1'b1;
                    in_op = 3'(op);
                    in_al = 8'(al);
                    in_ah = 8'(ah);
                    in_cf = fl[0];
                    in_af = fl[1];
                    @(negedge clk);
                    exp = ref_model(op, al, ah, fl % 2, fl / 2);
                    check(req_of(op), outs(), exp);
                    // R1: idle cycle holds the result with valid low
                    if (al % 64 == 0) begin
                        in_valid = 1'b0;
                        in_op = 3'(~op);
                        in_al = ~in_al;
                        held = {1'b0, exp[17:0]};
                        @(negedge clk);
                        check("R1", outs(), held);
                    end
                end
            end
        end

        // Boundary spot checks
        in_valid = 1'b1;
        in_op = 3'd0; in_al = 8'h9A; in_ah = 8'h11; in_cf = 1'b0; in_af = 1'b0;
        @(negedge clk);
        check("R3", outs(), {1'b1, 8'h00, 8'h11, 1'b1, 1'b1});
        in_op = 3'd2; in_al = 8'h0A; in_ah = 8'hFF; in_cf = 1'b0; in_af = 1'b0;
        @(negedge clk);
        check("R5", outs(), {1'b1, 8'h00, 8'h00, 1'b1, 1'b1});
        in_op = 3'd3; in_al = 8'h05; in_ah = 8'h00; in_cf = 1'b0; in_af = 1'b1;
        @(negedge clk);
        check("R6", outs(), {1'b1, 8'h0F, 8'hFF, 1'b1, 1'b1});
        in_op = 3'd4; in_al = 8'hFF; in_ah = 8'h00; in_cf = 1'b1; in_af = 1'b1;
        @(negedge clk);
        check("R7", outs(), {1'b1, 8'h05, 8'h19, 1'b0, 1'b0});
        in_op = 3'd5; in_al = 8'h09; in_ah = 8'h09; in_cf = 1'b1; in_af = 1'b0;
        @(negedge clk);
        check("R8", outs(), {1'b1, 8'h63, 8'h00, 1'b0, 1'b0});
        in_valid = 1'b0;
        @(negedge clk);
        check("R1", outs(), {1'b0, 8'h63, 8'h00, 1'b0, 1'b0});
        rst_n = 1'b0;
        @(negedge clk);
        check("R2", outs(), 19'h0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule